// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This combinational block sits in front of the ALU in a 32-bit RISC data path. It takes one operand and shifts or rotates it by an amount that comes either from a 5-bit immediate field of the instruction or from the low byte of a register. It returns the shifted operand together with the carry bit that the shift produces. The ALU uses that carry when a logical instruction sets the flags.

Five operations are available: logical left, logical right, arithmetic right, rotate right, and rotate right extended through the incoming carry. Amounts of zero, exactly the word width, and more than the word width each follow their own fixed rule. A zero amount means different things for the two amount sources. An immediate zero selects a special form of the operation. A register zero leaves the operand and the carry untouched.

Top module: `operand_shifter`

## Requirements
- R1: `kind` selects the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. `amt_from_reg`=1 takes the amount from `amt`, and 0 takes it from the immediate field.
- R2: A register amount uses all 8 bits of `amt` (0 to 255). An immediate amount uses only `amt[4:0]`, and `amt[7:5]` has no effect on either output.
- R3: A register amount of 0 passes the operand unchanged, with `carry_out` = `carry_in`, for every `kind`.
- R4: Logical left by n. For n=0 the operand and carry are unchanged. For n=1..31 the result is `op<<n` with carry `op[32-n]`. For n=32 the result is 0 with carry `op[0]`. For n>32 the result is 0 with carry 0.
- R5: Logical right. For an immediate 0 or n=32 the result is 0 with carry `op[31]`. For n=1..31 the result is `op>>n` with carry `op[n-1]`. For n>32 the result is 0 with carry 0.
- R6: Arithmetic right. For an immediate 0 or n>=32 every bit takes the value of `op[31]`, and carry is `op[31]`. For n=1..31 the result is a sign-filled shift with carry `op[n-1]`.
- R7: Rotate right with an immediate 0 gives rotate-extend: the result is `{carry_in, op[31:1]}` with carry `op[0]`.
- R8: Rotate right by a nonzero n uses r = n mod 32. For r=0 the operand is unchanged with carry `op[31]`. Otherwise the result is the operand rotated right by r, with carry `op[r-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 32 | Operand to shift |
| kind | input | 2 | Operation select (R1) |
| amt_from_reg | input | 1 | 1: amount from register byte, 0: from immediate field |
| amt | input | 8 | Shift amount; only bits 4:0 are used for an immediate |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
For every kind and both amount sources, directed vectors use the amounts 0, 1, 31, 32, 33 and 255. These separate the normal shift path from the zero, full-width and over-width rules, and they separate the immediate-zero reinterpretation from the register-zero no-op. The operands include all-ones, all-zeros, a lone sign bit and a lone low bit, so the carry taken from each end of the word can be seen. Immediate amounts with the upper bits of `amt` set show that those bits are ignored. Random operands, kinds, amounts and carries then cover bit positions in between, and each result is compared against a model that shifts one bit at a time.

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     op_in,
  input  logic [1:0]       kind,
  input  logic             amt_from_reg,
  input  logic [AMT_W-1:0] amt,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             carry_out
);
  // W must be a power of two; the rotate uses the low IMM_W amount bits.
  localparam int IMM_W = $clog2(W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

  logic [AMT_W-1:0] n;
  logic             zero_amt;
  logic [AMT_W-1:0] asr_n;
  logic [IMM_W-1:0] rot;
  logic [W:0]       lsl_x, lsr_x, asr_x;
  logic [2*W-1:0]   ror_x;

  assign n        = amt_from_reg ? amt : AMT_W'(amt[IMM_W-1:0]);
  assign zero_amt = (n == '0);
  assign asr_n    = (n >= FULL) ? FULL : n;
  assign rot      = n[IMM_W-1:0];

  assign lsl_x = {1'b0, op_in} << n;
  assign lsr_x = {op_in, 1'b0} >> n;
  assign asr_x = $unsigned($signed({op_in, 1'b0}) >>> asr_n);
  assign ror_x = {op_in, op_in} >> rot;

  always_comb begin
    result    = op_in;
    carry_out = carry_in;
    if (!(amt_from_reg && zero_amt)) begin
      unique case (kind)
        2'd0: if (!zero_amt) begin
          result    = lsl_x[W-1:0];
          carry_out = lsl_x[W];
        end
        2'd1: if (zero_amt) begin
          result    = '0;
          carry_out = op_in[W-1];
        end else begin
          result    = lsr_x[W:1];
          carry_out = lsr_x[0];
        end
        2'd2: if (zero_amt) begin
          result    = {W{op_in[W-1]}};
          carry_out = op_in[W-1];
        end else begin
          result    = asr_x[W:1];
          carry_out = asr_x[0];
        end
        default: if (zero_amt) begin
          result    = {carry_in, op_in[W-1:1]};
          carry_out = op_in[0];
        end else begin
          result    = ror_x[W-1:0];
          carry_out = ror_x[W-1];
        end
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({op_in, kind, amt_from_reg, amt, carry_in})) begin
      a_r3_reg_zero_passthrough: assert (!(amt_from_reg && amt == '0) ||
                                         (result == op_in && carry_out == carry_in));
      a_r4_lsl_low_clear: assert (!(kind == 2'd0 && !zero_amt) || !result[0]);
      a_r5_lsr_top_clear: assert (!(kind == 2'd1 && !(amt_from_reg && zero_amt)) || !result[W-1]);
      a_r6_asr_sign_kept: assert (kind != 2'd2 || result[W-1] == op_in[W-1]);
      a_r8_ror_ones_kept: assert (!(kind == 2'd3 && !zero_amt) ||
                                  $countones(result) == $countones(op_in));
    end
  end
endmodule

// File: tb/test_operand_shifter.sv
`timescale 1ns/1ps
module test_operand_shifter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] op_in, result;
  logic [1:0]  kind;
  logic        amt_from_reg, carry_in, carry_out;
  logic [7:0]  amt;
  int vectors = 0, fails = 0;

  operand_shifter i_operand_shifter (
    .op_in(op_in), .kind(kind), .amt_from_reg(amt_from_reg), .amt(amt),
    .carry_in(carry_in), .result(result), .carry_out(carry_out));

  // Reference: apply the shift one bit at a time, special zero rules by hand.
  function automatic logic [32:0] ref_model(logic [31:0] op, logic [1:0] k,
                                            logic from_reg, logic [7:0] a, logic cin);
    logic [31:0] v = op;
    logic c = cin;
    int cnt = from_reg ? int'(a) : int'(a[4:0]);
    if (cnt == 0) begin
      if (from_reg || k == 2'd0) return {cin, op};
      if (k == 2'd1) return {op[31], 32'h0};
      if (k == 2'd2) return {op[31], {32{op[31]}}};
      return {op[0], cin, op[31:1]};
    end
    for (int i = 0; i < cnt; i++) begin
      case (k)
        2'd0: begin c = v[31]; v = v << 1; end
        2'd1: begin c = v[0]; v = v >> 1; end
        2'd2: begin c = v[0]; v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  function automatic string tag_of(logic [1:0] k, logic from_reg, logic [7:0] a);
    if (from_reg && a == 0) return "R3";
    if (!from_reg && a[7:5] != 0) return "R2";
    case (k)
      2'd0: return "R1/R4";
      2'd1: return "R1/R5";
      2'd2: return "R1/R6";
      default: return (!from_reg && a[4:0] == 0) ? "R7" : "R1/R8";
    endcase
  endfunction

  task automatic apply(logic [31:0] op, logic [1:0] k, logic fr, logic [7:0] a, logic cin);
    logic [32:0] exp;
    @(posedge clk);
    op_in = op; kind = k; amt_from_reg = fr; amt = a; carry_in = cin;
    @(negedge clk);
    exp = ref_model(op, k, fr, a, cin);
    vectors++;
    if ({carry_out, result} !== exp) begin
      fails++;
      $display("FAIL %s op=%h kind=%0d reg=%0b amt=%0d cin=%0b: got c=%0b r=%h, expected c=%0b r=%h",
               tag_of(k, fr, a), op, k, fr, a, cin, carry_out, result, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] ops [5];
    logic [7:0]  amts [6];
    void'($urandom(32'h5eed_0b17));
    ops  = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0001, 32'hA5C3_3C5A};
    amts = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};
    apply(32'h0, 2'd0, 1'b0, 8'd0, 1'b0);
    // R1 R4 R5 R6 R7 R8: every kind, corner amounts, both sources and carries
    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 5; o++)
        for (int a = 0; a < 6; a++)
          for (int fr = 0; fr < 2; fr++)
            for (int c = 0; c < 2; c++)
              apply(ops[o], 2'(k), 1'(fr), amts[a], 1'(c));
    // R3: register zero for every kind
    for (int k = 0; k < 4; k++) apply(32'h1357_9BDF, 2'(k), 1'b1, 8'd0, 1'b1);
    // R2: immediate upper bits ignored
    for (int k = 0; k < 4; k++) begin
      apply(32'h8421_0F0F, 2'(k), 1'b0, 8'hE0, 1'b1);
      apply(32'h8421_0F0F, 2'(k), 1'b0, 8'hA7, 1'b0);
    end
    for (int i = 0; i < 3000; i++)
      apply($urandom, 2'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule